// File: doc/BRIEF.md
# Latched-Address Host Bus Front End

This block sits between an asynchronous host bus and an 8-bit peripheral that has eight internal registers. It takes a 3-bit register index, three chip selects (two active-high, one active-low), an active-low address strobe, and read and write strobes that each come in an active-high and an active-low form. It brings every host input into the system clock domain, decides whether the peripheral is addressed, and produces a registered register index, a combined select, one-cycle read and write enables, and an enable for the data bus drivers.

Some hosts share pins between address and data. For them, a low-to-high transition on the address strobe captures the index and the chip selects, and the block keeps those captured values until the next such transition. Hosts whose address lines stay stable for the whole access tie the strobe low, and the index and selects then pass straight through. For each strobe pair, the host drives one member and ties the other to its inactive level.

Top module: `hbi_front`

## Requirements
- R1: After reset, reg_addr is 0 and dev_sel, rd_en, wr_en and bus_oe are all 0. The captured index and selects reset to the deselected state.
- R2: dev_sel is 1 only when cs_a=1, cs_b=1 and cs_n=0. The other seven combinations give dev_sel=0.
- R3: While as_n is held at 0, reg_addr and dev_sel follow addr and the chip selects. They change on the third rising clock edge after the inputs change.
- R4: A 0-to-1 transition on as_n captures addr and the chip selects. While as_n stays at 1, changes on those inputs have no effect on reg_addr, dev_sel or on which register an access uses.
- R5: A read strobe is active when rd_n=0 or when rd=1. Either member alone starts a read.
- R6: A write strobe is active when wr_n=0 or when wr=1. Either member alone starts a write.
- R7: A selected read produces rd_en=1 for exactly one cycle, on the third rising edge after the read strobe becomes active.
- R8: A selected write produces wr_en=1 for exactly one cycle, on the third rising edge after the write strobe becomes active.
- R9: bus_oe is 1 only while a selected read is in progress. It rises together with rd_en and falls on the third rising edge after the read strobe ends.
- R10: When read and write strobes are active in the same cycle, the write is ignored (wr_en stays 0) and the read proceeds.
- R11: When the peripheral is not selected, strobes produce no rd_en, wr_en or bus_oe.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe; a rising transition captures the index and selects, and 0 means pass-through |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Register index |
| rd_n | input | 1 | Read strobe, active low |
| rd | input | 1 | Read strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| wr | input | 1 | Write strobe, active high |
| reg_addr | output | ADDR_W | Registered register index of the current access |
| dev_sel | output | 1 | Registered combined chip select |
| rd_en | output | 1 | One-cycle read enable |
| wr_en | output | 1 | One-cycle write enable |
| bus_oe | output | 1 | Data bus output enable during a selected read |

## Verification
A wrong captured index or select would show up on reg_addr and dev_sel within three clock edges. Every access that follows would then use the wrong register or be dropped, and the latched-mode test exposes this by changing the address lines after the strobe edge. A wrong edge-detect state would show up in rd_en or wr_en: a pulse that lasts longer than one cycle, a pulse that comes twice, or no pulse at all. A wrong read-level state would show up in bus_oe as a stuck-high enable or one that drops early. Each of these is visible at the ports no later than four edges after the strobe changes.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Combined select: two active-high selects and one active-low select.
  function automatic logic chip_hit(input logic a, input logic b, input logic n);
    return a & b & ~n;
  endfunction

  // A strobe pair is active when either its low-true or high-true member asserts.
  function automatic logic strobe_on(input logic lo_n, input logic hi);
    return ~lo_n | hi;
  endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbi_addr_hold.sv
module hbi_addr_hold #(
  parameter int           W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] live,
  output logic [W-1:0] eff
);
  logic [W-1:0] lat;

  // Track while the strobe is low; the value seen just before the rise is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat <= RST_VAL;
    else if (!hold) lat <= live;
  end

  assign eff = hold ? lat : live;

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(lat));
endmodule

// File: rtl/hbi_access.sv
module hbi_access #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_hit,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_lvl,
  input  logic              wr_lvl,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              dev_sel,
  output logic              rd_en,
  output logic              wr_en,
  output logic              bus_oe
);
  logic rd_go, wr_go, wr_q;

  assign rd_go = rd_lvl & sel_hit;
  assign wr_go = wr_lvl & ~rd_lvl & sel_hit;   // read wins a collision

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr <= '0;
      dev_sel  <= 1'b0;
      rd_en    <= 1'b0;
      wr_en    <= 1'b0;
      bus_oe   <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      reg_addr <= addr_in;
      dev_sel  <= sel_hit;
      rd_en    <= rd_go & ~bus_oe;
      bus_oe   <= rd_go;
      wr_en    <= wr_go & ~wr_q;
      wr_q     <= wr_go;
    end
  end

  p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_oe_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> dev_sel);
  p_rd_with_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (bus_oe && dev_sel));
  p_no_wr_in_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bus_oe));
  p_wr_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> dev_sel);
endmodule

// File: rtl/hbi_front.sv
module hbi_front #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              rd,
  input  logic              wr_n,
  input  logic              wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              dev_sel,
  output logic              rd_en,
  output logic              wr_en,
  output logic              bus_oe
);
  localparam int HOLD_W = ADDR_W + 3;
  localparam int SYNC_W = HOLD_W + 5;
  // Idle: strobe low (pass-through), deselected, no access strobes.
  localparam logic [HOLD_W-1:0] HOLD_RST = {1'b0, 1'b0, 1'b1, {ADDR_W{1'b0}}};
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, HOLD_RST};

  logic [SYNC_W-1:0] raw_s;
  logic [HOLD_W-1:0] live_s, eff;
  logic              as_s, rd_n_s, rd_s, wr_n_s, wr_s;
  logic              sel_hit, rd_lvl, wr_lvl;

  hbi_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({as_n, rd_n, rd, wr_n, wr, cs_a, cs_b, cs_n, addr}),
    .q(raw_s)
  );

  assign {as_s, rd_n_s, rd_s, wr_n_s, wr_s, live_s} = raw_s;

  hbi_addr_hold #(.W(HOLD_W), .RST_VAL(HOLD_RST)) u_hold (
    .clk(clk), .rst_n(rst_n), .hold(as_s), .live(live_s), .eff(eff)
  );

  assign sel_hit = hbi_pkg::chip_hit(eff[HOLD_W-1], eff[HOLD_W-2], eff[HOLD_W-3]);
  assign rd_lvl  = hbi_pkg::strobe_on(rd_n_s, rd_s);
  assign wr_lvl  = hbi_pkg::strobe_on(wr_n_s, wr_s);

  hbi_access #(.ADDR_W(ADDR_W)) u_access (
    .clk(clk), .rst_n(rst_n), .sel_hit(sel_hit), .addr_in(eff[ADDR_W-1:0]),
    .rd_lvl(rd_lvl), .wr_lvl(wr_lvl),
    .reg_addr(reg_addr), .dev_sel(dev_sel), .rd_en(rd_en), .wr_en(wr_en),
    .bus_oe(bus_oe)
  );

  p_sel_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (eff[HOLD_W-1] && eff[HOLD_W-2] && !eff[HOLD_W-3]));
endmodule

// File: tb/tb_hbi_front.sv
module tb_hbi_front;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       as_n = 1'b0, cs_a = 1'b0, cs_b = 1'b0, cs_n = 1'b1;
  logic [2:0] addr = '0;
  logic       rd_n = 1'b1, rd = 1'b0, wr_n = 1'b1, wr = 1'b0;
  logic [2:0] reg_addr;
  logic       dev_sel, rd_en, wr_en, bus_oe;
  int checks = 0, errors = 0;

  always #2ns clk = ~clk;

  hbi_front dut (.clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_a(cs_a), .cs_b(cs_b),
    .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .rd(rd), .wr_n(wr_n), .wr(wr),
    .reg_addr(reg_addr), .dev_sel(dev_sel), .rd_en(rd_en), .wr_en(wr_en), .bus_oe(bus_oe));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic select(input logic on, input logic [2:0] a);
    cs_a = on; cs_b = on; cs_n = ~on; addr = a;
  endtask

  task automatic strobe_rd(input logic hi_pol, input logic on);
    if (hi_pol) rd = on; else rd_n = ~on;
  endtask

  task automatic strobe_wr(input logic hi_pol, input logic on);
    if (hi_pol) wr = on; else wr_n = ~on;
  endtask

  // Full read: enable pulse on third edge, oe drops third edge after release.
  task automatic do_read(input logic hi_pol, input int exp_addr, input string req);
    strobe_rd(hi_pol, 1'b1);
    step(2); check({req, " R7 rd_en early"}, rd_en, 0);
    step(1); check({req, " R7 rd_en"}, rd_en, 1);
    check({req, " R9 bus_oe rise"}, bus_oe, 1);
    check({req, " reg_addr"}, reg_addr, exp_addr);
    step(1); check({req, " R7 single pulse"}, rd_en, 0);
    check({req, " R9 bus_oe held"}, bus_oe, 1);
    strobe_rd(hi_pol, 1'b0);
    step(2); check({req, " R9 bus_oe before fall"}, bus_oe, 1);
    step(1); check({req, " R9 bus_oe fall"}, bus_oe, 0);
  endtask

  task automatic do_write(input logic hi_pol, input int exp_addr, input string req);
    strobe_wr(hi_pol, 1'b1);
    step(3); check({req, " R8 wr_en"}, wr_en, 1);
    check({req, " reg_addr"}, reg_addr, exp_addr);
    check({req, " R9 no oe on write"}, bus_oe, 0);
    step(1); check({req, " R8 single pulse"}, wr_en, 0);
    strobe_wr(hi_pol, 1'b0);
    step(3);
  endtask

  task automatic t_reset();
    check("R1 reg_addr", reg_addr, 0); check("R1 dev_sel", dev_sel, 0);
    check("R1 rd_en", rd_en, 0); check("R1 wr_en", wr_en, 0); check("R1 bus_oe", bus_oe, 0);
  endtask

  task automatic t_decode();
    for (int i = 0; i < 8; i++) begin
      cs_a = i[2]; cs_b = i[1]; cs_n = i[0];
      step(3);
      check($sformatf("R2 decode combo %0d", i), dev_sel, (i == 6) ? 1 : 0);
    end
  endtask

  task automatic t_transparent();
    as_n = 1'b0;
    select(1'b1, 3'd3);
    step(2); check("R3 not yet", reg_addr == 3'd3, 0);
    step(1); check("R3 addr follows", reg_addr, 3);
    addr = 3'd6; step(3); check("R3 addr follows again", reg_addr, 6);
    do_read(1'b0, 6, "R3 transparent read");
  endtask

  task automatic t_latched();
    as_n = 1'b0; select(1'b1, 3'd5);
    step(2); as_n = 1'b1;
    step(1); select(1'b0, 3'd2);
    step(4);
    check("R4 addr held", reg_addr, 5); check("R4 sel held", dev_sel, 1);
    do_read(1'b1, 5, "R4 latched read");
    do_write(1'b0, 5, "R4 latched write");
    as_n = 1'b0; step(4);
    check("R3 pass-through resumes", reg_addr, 2); check("R3 deselect resumes", dev_sel, 0);
  endtask

  task automatic t_polarity(input logic rp, input logic wp);
    as_n = 1'b0; select(1'b1, {1'b0, rp, wp});
    step(3);
    do_write(wp, {1'b0, rp, wp}, wp ? "R6 wr high" : "R6 wr_n low");
    do_read(rp, {1'b0, rp, wp}, rp ? "R5 rd high" : "R5 rd_n low");
  endtask

  task automatic t_collision();
    as_n = 1'b0; select(1'b1, 3'd7); step(3);
    rd_n = 1'b0; wr = 1'b1;
    step(3); check("R10 read proceeds", rd_en, 1); check("R10 write ignored", wr_en, 0);
    step(1); check("R10 write still ignored", wr_en, 0);
    rd_n = 1'b1; wr = 1'b0; step(4);
  endtask

  task automatic t_unselected();
    as_n = 1'b0; select(1'b0, 3'd1); step(3);
    rd = 1'b1; step(3);
    check("R11 no rd_en", rd_en, 0); check("R11 no bus_oe", bus_oe, 0);
    rd = 1'b0; wr_n = 1'b0; step(3);
    check("R11 no wr_en", wr_en, 0);
    wr_n = 1'b1; step(3);
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_decode();
    t_transparent();
    t_latched();
    for (int p = 0; p < 4; p++) t_polarity(p[1], p[0]);
    t_collision();
    t_unselected();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule